// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits between a serial-bus front end and a 256-byte storage array. After the front end has decoded a word address, each data byte it receives goes into a 16-byte page latch. The upper four bits of the address pick the page and stay fixed. The lower four bits select the byte slot and advance after every byte. They wrap inside the page, so a long burst overwrites the slots it filled earlier.

When a stop condition closes a write that holds at least one byte, the block starts a timed write cycle. The cycle length is `CYCLE_TICKS` clock ticks and is a parameter. For the whole cycle `busy` is high, and so is `nack_req`, which tells the front end to withhold acknowledge. When the cycle ends, only the slots that were actually loaded are copied into the array in a single clock. A start condition before the stop throws the pending data away. A high write-protect input at the stop, or at any point during the cycle, leaves the array unchanged.

The array can be read at any time through an asynchronous read port.

Top module: `page_write_seq`

## Requirements
- R1: After synchronous reset, `busy` and `nack_req` are low and every array byte reads 0x00.
- R2: After `addr_load`, each accepted `byte_stb` stores its byte at array address {upper 4 bits of the loaded address, current slot}. The slot starts at the loaded low 4 bits and increments modulo 16 after each byte. The upper 4 bits never change.
- R3: When more than 16 bytes arrive in one write, each slot holds the last byte written to it. This makes the final 16 bytes the survivors.
- R4: Only slots loaded during the current write are committed. Every other byte of the page, and every other page, keeps its old value.
- R5: A write cycle launches only on `stop_stb` that follows an `addr_load` and at least one byte. A stop with no data byte starts no cycle and changes nothing.
- R6: `busy` rises on the clock after the launching stop and stays high for exactly `CYCLE_TICKS` cycles. The array shows the new data from the cycle in which `busy` is first low again.
- R7: `nack_req` is high exactly when `busy` is high.
- R8: A `start_stb` that arrives before the stop discards the pending bytes. No cycle starts and the array is unchanged.
- R9: If `wp` is high when the stop arrives, no cycle starts, the pending bytes are discarded and the array is unchanged.
- R10: If `wp` is high in any clock while `busy` is high, the array is unchanged after the cycle. `busy` still lasts `CYCLE_TICKS` cycles.
- R11: While `busy` is high, `addr_load`, `byte_stb`, `start_stb` and `stop_stb` are ignored. Bytes sent then are never committed, and a later stop starts no cycle.
- R12: `rd_data` equals the array byte at `rd_addr` without any clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_stb | input | 1 | One-cycle pulse: start condition seen |
| stop_stb | input | 1 | One-cycle pulse: stop condition seen |
| addr_load | input | 1 | One-cycle pulse: word address valid on `addr_in` |
| addr_in | input | 8 | Word address |
| byte_stb | input | 1 | One-cycle pulse: data byte received (end of 8th bit) |
| byte_in | input | 8 | Received data byte |
| wp | input | 1 | Write protect, active high |
| rd_addr | input | 8 | Read port address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| busy | output | 1 | Write cycle in progress |
| nack_req | output | 1 | Front end must withhold acknowledge |

## Verification
A sweep covers every page. Each page gets a different burst length from 1 to 16 and a different starting slot, and the whole array is compared after every cycle. This separates correct slot placement and in-page wrap from writes that leak into neighbouring slots or pages. Bursts of 20 bytes and short rewrites of a page that already holds data show whether later bytes overwrite earlier ones while untouched slots keep their contents. Further sequences show which events cancel a write and which leave the array alone: a start before the stop, a stop with no data, write-protect at the stop, write-protect during the cycle, and traffic sent while busy.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int OFS_W      = 4;
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int PG_W       = ADDR_W - OFS_W;
    localparam int DEPTH      = 1 << ADDR_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [PG_W-1:0]   pg_t;

    typedef struct packed {
        pg_t                           page;
        logic [PAGE_BYTES-1:0]         mask;
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
    } page_img_t;

    function automatic ofs_t ofs_next(input ofs_t o);
        return ofs_t'(o + ofs_t'(1));
    endfunction

    function automatic logic [ADDR_W-1:0] join_addr(input pg_t p, input ofs_t o);
        return {p, o};
    endfunction
endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch
    import pwb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  load_addr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  byte_t                 wr_data,
    output page_img_t             img,
    output logic                  has_data
);
    pg_t  page_q;
    ofs_t ofs_q;
    logic [PAGE_BYTES-1:0]             mask_q;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mask_q <= '0;
            if (rst) begin
                page_q <= '0;
                ofs_q  <= '0;
                data_q <= '0;
            end
        end else if (load_addr) begin
            page_q <= addr[ADDR_W-1:OFS_W];
            ofs_q  <= addr[OFS_W-1:0];
            mask_q <= '0;
        end else if (wr_en) begin
            data_q[ofs_q] <= wr_data;
            mask_q[ofs_q] <= 1'b1;
            ofs_q         <= ofs_next(ofs_q);
        end
    end

    assign img      = '{page: page_q, mask: mask_q, data: data_q};
    assign has_data = |mask_q;

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clear && !load_addr) |=> (page_q == $past(page_q))); // R2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clear && !load_addr) |=> (ofs_q == ofs_t'($past(ofs_q) + ofs_t'(1)))); // R2
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int CYCLE_TICKS = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic wp,
    output logic busy,
    output logic done,
    output logic inhibit
);
    localparam int CNT_W = $clog2(CYCLE_TICKS + 1);
    logic [CNT_W-1:0] cnt_q;
    logic             wp_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt_q     <= '0;
            wp_seen_q <= 1'b0;
        end else if (launch && !busy) begin
            busy      <= 1'b1;
            cnt_q     <= CNT_W'(CYCLE_TICKS - 1);
            wp_seen_q <= 1'b0;
        end else if (busy) begin
            if (wp) wp_seen_q <= 1'b1;
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done    = busy && (cnt_q == '0);
    assign inhibit = wp_seen_q || wp;

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != '0) |=> busy); // R6
    AST_CNT_LOADED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cnt_q == CNT_W'(CYCLE_TICKS - 1))); // R6
endmodule

// File: rtl/pwb_store.sv
module pwb_store
    import pwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  page_img_t         img,
    input  logic [ADDR_W-1:0] rd_addr,
    output byte_t             rd_data
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (we) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (img.mask[i]) mem[join_addr(img.page, ofs_t'(i))] <= img.data[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

    AST_HOLD_WITHOUT_WE: assert property (@(posedge clk) disable iff (rst)
        (!we && $stable(rd_addr)) |=> (rd_data == $past(rd_data) || rd_addr != $past(rd_addr))); // R10
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
    import pwb_pkg::*;
#(
    parameter int CYCLE_TICKS = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_stb,
    input  logic              stop_stb,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              wp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              nack_req
);
    logic      armed_q;
    logic      has_data, launch, done, inhibit, arr_we;
    logic      lat_clear, lat_load, lat_wr;
    page_img_t img;

    assign launch    = !busy && stop_stb && !start_stb && armed_q && has_data && !wp;
    assign lat_load  = !busy && addr_load && !start_stb && !stop_stb;
    assign lat_wr    = !busy && byte_stb && armed_q && !start_stb && !stop_stb && !addr_load;
    assign arr_we    = done && !inhibit;
    assign lat_clear = done || (!busy && (start_stb || (stop_stb && !launch)));

    always_ff @(posedge clk) begin
        if (rst)                                  armed_q <= 1'b0;
        else if (!busy && (start_stb || stop_stb)) armed_q <= 1'b0;
        else if (lat_load)                        armed_q <= 1'b1;
    end

    pwb_page_latch u_latch (
        .clk(clk), .rst(rst), .clear(lat_clear), .load_addr(lat_load),
        .addr(addr_in), .wr_en(lat_wr), .wr_data(byte_in),
        .img(img), .has_data(has_data)
    );

    pwb_cycle_timer #(.CYCLE_TICKS(CYCLE_TICKS)) u_timer (
        .clk(clk), .rst(rst), .launch(launch), .wp(wp),
        .busy(busy), .done(done), .inhibit(inhibit)
    );

    pwb_store u_store (
        .clk(clk), .rst(rst), .we(arr_we), .img(img),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign nack_req = busy;

    AST_WP_BLOCKS_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (stop_stb && wp && !busy) |=> !busy); // R9
    AST_START_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (start_stb && !busy) |=> !busy); // R8
endmodule

// File: tb/page_write_seq_tb.sv
module page_write_seq_tb;
    localparam int TICKS = 8;
    logic clk = 0, rst = 1;
    logic start_stb = 0, stop_stb = 0, addr_load = 0, byte_stb = 0, wp = 0;
    logic [7:0] addr_in = 0, byte_in = 0, rd_addr = 0, rd_data;
    logic busy, nack_req;
    logic [7:0] model [256];
    int n_run = 0, n_fail = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    page_write_seq #(.CYCLE_TICKS(TICKS)) u_dut (
        .clk(clk), .rst(rst), .start_stb(start_stb), .stop_stb(stop_stb),
        .addr_load(addr_load), .addr_in(addr_in), .byte_stb(byte_stb),
        .byte_in(byte_in), .wp(wp), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .nack_req(nack_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(); start_stb = 1; @(negedge clk); start_stb = 0; endtask
    task automatic pulse_stop();  stop_stb  = 1; @(negedge clk); stop_stb  = 0; endtask
    task automatic load(input int a);
        addr_in = 8'(a); addr_load = 1; @(negedge clk); addr_load = 0;
    endtask
    task automatic send(input int b);
        byte_in = 8'(b); byte_stb = 1; @(negedge clk); byte_stb = 0;
    endtask

    // count busy cycles (R6) and check nack_req tracks busy (R7)
    task automatic wait_cycle(input string req, input int exp_len);
        int n = 0;
        bit nk_ok = 1;
        while (busy && n < 10 * TICKS) begin
            if (nack_req !== 1'b1) nk_ok = 0;
            n++;
            @(negedge clk);
        end
        if (nack_req !== 1'b0) nk_ok = 0;
        chk(n == exp_len, {req, " R6 busy length"}, n, exp_len);
        chk(nk_ok, "R7 nack_req follows busy", 0, 1);
    endtask

    task automatic cmp_array(input string req);
        int bad = 0, fa = 0, fe = 0;
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a); #0.1;
            if (rd_data !== model[a]) begin
                if (bad == 0) begin fa = rd_data; fe = model[a]; end
                bad++;
            end
        end
        chk(bad == 0, {req, " R12 array contents"}, fa, fe);
    endtask

    task automatic page_write(input int a, input int len, input int seed);
        pulse_start();
        load(a);
        for (int i = 0; i < len; i++) begin
            int d = (seed * 37 + i * 11 + 1) & 255;
            send(d);
            model[{a[7:4], 4'((a + i) & 15)}] = 8'(d);
        end
        pulse_stop();
    endtask

    initial begin
        for (int a = 0; a < 256; a++) model[a] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && nack_req == 0, "R1 reset busy", busy, 0);
        cmp_array("R1");

        // R2 R4: sweep all pages, lengths 1..16, varying start slot
        for (int p = 0; p < 16; p++) begin
            page_write(p * 16 + ((p * 5) % 16), p + 1, p);
            chk(busy == 1, "R5 stop launches cycle", busy, 1);
            wait_cycle("R2", TICKS);
            cmp_array("R2 R4 sweep");
        end

        // R3: 20 bytes from slot 14 of page 3
        page_write(8'h3E, 20, 99);
        wait_cycle("R3", TICKS);
        cmp_array("R3 wrap overwrite");

        // R4: short rewrite keeps other slots of the page
        page_write(8'h37, 2, 55);
        wait_cycle("R4", TICKS);
        cmp_array("R4 partial keep");

        // R5: stop with no data byte
        pulse_start(); load(8'h50); pulse_stop();
        chk(busy == 0, "R5 no data no cycle", busy, 0);
        cmp_array("R5");

        // R8: start before stop discards
        pulse_start(); load(8'h60); send(8'hAA); send(8'hBB);
        pulse_start(); pulse_stop();
        chk(busy == 0, "R8 start discards", busy, 0);
        cmp_array("R8");

        // R9: wp at stop
        pulse_start(); load(8'h70); send(8'hCC);
        wp = 1; pulse_stop(); wp = 0;
        chk(busy == 0, "R9 wp at stop", busy, 0);
        pulse_stop();
        chk(busy == 0, "R9 data discarded", busy, 0);
        cmp_array("R9");

        // R10: wp pulse during busy
        pulse_start(); load(8'h80); send(8'h11); send(8'h22);
        pulse_stop();
        @(negedge clk); wp = 1; @(negedge clk); wp = 0;
        wait_cycle("R10", TICKS - 2);
        cmp_array("R10 wp during cycle");

        // R11: traffic while busy is ignored
        page_write(8'h90, 1, 7);
        load(8'hA0); send(8'h5A); send(8'h5B); pulse_stop();
        wait_cycle("R11", TICKS - 4);
        cmp_array("R11 after cycle");
        pulse_stop();
        chk(busy == 0, "R11 no stale launch", busy, 0);
        cmp_array("R11");

        done_flag = 1;
    end

    initial begin
        int cyc = 0;
        while (!done_flag && cyc < 100000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done_flag) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule